// File: doc/BRIEF.md
# Clock Alarm Output Combiner

This block turns raw per-input clock health indications into the alarm levels that leave the chip. It takes four loss-of-signal bits, two frequency-offset bits, a frame-alignment alarm and a frame-sync switching control, and forms the levels for two per-clock alarm pins. Each pin is an OR of its own clock's loss-of-signal term, a frame-sync input's loss-of-signal term that only counts while frame-sync switching is on, and a frequency-offset term that only counts while frequency-offset alarms are enabled. A third per-clock pin stays undriven in this configuration. A shared pin carries either the frame-alignment alarm or the interrupt.

Every raw bit also feeds a sticky flag. A flag sets on a rising edge of its raw bit and is cleared by a write-one-to-clear strobe. Masked flags are ORed into a registered interrupt. A polarity bit makes all pin levels active-low. Output enables are separate ports, so the pad ring builds the tri-state buffers. The block does not detect alarms itself. It sits between the clock monitors and the pads and status registers.

Top module: `clk_alarm_combiner`

## Requirements
- R1: Pin A is asserted when los_raw[0] is 1, or when los_raw[2] and fsync_switch are both 1, or when fos_en and fos_raw[0] are both 1. The pin level appears one clock after the inputs.
- R2: Pin B is asserted when los_raw[1] is 1, or when los_raw[3] and fsync_switch are both 1, or when fos_en and fos_raw[1] are both 1. The pin level appears one clock after the inputs.
- R3: Pin C has no enable in this configuration. pinc_oe is always 0, and pinc_val holds the inactive level.
- R4: When int_sel is 0, the shared pin carries align_alarm one clock later.
- R5: pina_oe, pinb_oe and shr_oe follow pin_en bit 0, bit 1 and bit 2 one clock later. shr_oe is also 1 whenever int_sel was 1.
- R6: When int_sel is 1, the shared pin carries the interrupt level in the same cycle that irq shows it, whatever pin_en bit 2 is.
- R7: raw_status shows the raw inputs one clock later. Bits 0 to 3 are los_raw[0..3] and bits 4 and 5 are fos_raw[0..1].
- R8: A sticky_status bit (same bit layout as raw_status) becomes 1 one clock after its raw bit goes from 0 to 1. It then holds until it is cleared.
- R9: clr_flags bit i clears sticky bit i one clock later. A rising edge in the same cycle wins, and the bit stays 1.
- R10: irq is 1 exactly when some sticky bit and its mask bit (1 = enabled) were both 1 on the previous clock.
- R11: When active_low is 1, pina_val, pinb_val, pinc_val and shr_val show the inverse of the active-high levels.
- R12: A synchronous active-high reset clears every output, status bit and flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| los_raw | input | 4 | Raw loss-of-signal bits; inputs 3 and 4 are the frame-sync inputs |
| fos_raw | input | 2 | Raw frequency-offset bits for inputs 1 and 2 |
| align_alarm | input | 1 | Frame-alignment alarm |
| fsync_switch | input | 1 | Includes frame-sync input loss-of-signal in the pin alarms |
| fos_en | input | 1 | Includes frequency-offset terms in the pin alarms |
| pin_en | input | 3 | Drive enables for pin A, pin B and the shared pin |
| int_sel | input | 1 | Shared pin carries the interrupt instead of the alignment alarm |
| active_low | input | 1 | Pin polarity select |
| mask | input | 6 | Interrupt enable for each sticky flag |
| clr_flags | input | 6 | Write-one-to-clear strobes for the sticky flags |
| pina_val | output | 1 | Pin A level |
| pina_oe | output | 1 | Pin A drive enable |
| pinb_val | output | 1 | Pin B level |
| pinb_oe | output | 1 | Pin B drive enable |
| pinc_val | output | 1 | Pin C level (always inactive) |
| pinc_oe | output | 1 | Pin C drive enable (always 0) |
| shr_val | output | 1 | Shared alarm/interrupt pin level |
| shr_oe | output | 1 | Shared pin drive enable |
| raw_status | output | 6 | Registered raw alarm bits |
| sticky_status | output | 6 | Sticky alarm flags |
| irq | output | 1 | Interrupt, active high |

## Verification
Every result, including the pin levels, enables, raw status, sticky flags, irq and the shared pin, is due exactly one clock after the input cycle that causes it. The interrupt is also due one clock after the sticky state it reads. The driver applies each input set at a falling edge. It computes the expected vector from a model of the requirements and queues that vector, tagged with the due cycle count. The monitor compares each vector at the falling edge of that cycle, so no check samples near an active edge.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
  localparam int NUM_LOS   = 4;
  localparam int NUM_FOS   = 2;
  localparam int NUM_FLAGS = NUM_LOS + NUM_FOS;
  localparam int NUM_EN    = 3;
  localparam int EN_A      = 0;
  localparam int EN_B      = 1;
  localparam int EN_SHR    = 2;

  function automatic logic pad_level(input logic active, input logic low_true);
    return active ^ low_true;
  endfunction
endpackage

// File: rtl/alarm_flag_bank.sv
module alarm_flag_bank #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  input  logic [WIDTH-1:0] clr,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] raw_q,
  output logic [WIDTH-1:0] sticky_q,
  output logic             irq_next,
  output logic             irq_q
);
  logic [WIDTH-1:0] rise;

  assign rise     = raw_in & ~raw_q;
  assign irq_next = |(sticky_q & mask);

  for (genvar i = 0; i < WIDTH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[i]    <= 1'b0;
        sticky_q[i] <= 1'b0;
      end else begin
        raw_q[i] <= raw_in[i];
        if (rise[i])
          sticky_q[i] <= 1'b1;
        else if (clr[i])
          sticky_q[i] <= 1'b0;
      end
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
      (raw_in[i] && !raw_q[i]) |=> sticky_q[i]);  // R8
    AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !(raw_in[i] && !raw_q[i])) |=> !sticky_q[i]);  // R9
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_next;
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|(sticky_q & mask)) |=> irq_q);  // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|(sticky_q & mask)) |=> !irq_q);  // R10
endmodule

// File: rtl/alarm_pin_drive.sv
module alarm_pin_drive
  import clk_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOS-1:0] los,
  input  logic [NUM_FOS-1:0] fos,
  input  logic               align,
  input  logic               fsync,
  input  logic               fos_en,
  input  logic [NUM_EN-1:0]  pin_en,
  input  logic               int_sel,
  input  logic               active_low,
  input  logic               irq_level,
  output logic               a_val,
  output logic               a_oe,
  output logic               b_val,
  output logic               b_oe,
  output logic               c_val,
  output logic               c_oe,
  output logic               s_val,
  output logic               s_oe
);
  logic a_act, b_act, s_act;

  always_comb begin
    a_act = los[0] | (los[2] & fsync) | (fos_en & fos[0]);
    b_act = los[1] | (los[3] & fsync) | (fos_en & fos[1]);
    s_act = int_sel ? irq_level : align;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_val <= 1'b0;
      b_val <= 1'b0;
      c_val <= 1'b0;
      s_val <= 1'b0;
      a_oe  <= 1'b0;
      b_oe  <= 1'b0;
      c_oe  <= 1'b0;
      s_oe  <= 1'b0;
    end else begin
      a_val <= pad_level(a_act, active_low);
      b_val <= pad_level(b_act, active_low);
      c_val <= pad_level(1'b0, active_low);
      s_val <= pad_level(s_act, active_low);
      a_oe  <= pin_en[EN_A];
      b_oe  <= pin_en[EN_B];
      c_oe  <= 1'b0;
      s_oe  <= pin_en[EN_SHR] | int_sel;
    end
  end

  AST_PIN_A_LOS: assert property (@(posedge clk) disable iff (rst)
    (los[0] && !active_low) |=> a_val);  // R1
  AST_PIN_B_GATED: assert property (@(posedge clk) disable iff (rst)
    (!los[1] && !fsync && !fos_en && !active_low) |=> !b_val);  // R2
  AST_SHR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (!int_sel && !active_low && align) |=> s_val);  // R4
  AST_OE_TRACK: assert property (@(posedge clk) disable iff (rst)
    pin_en[EN_A] |=> a_oe);  // R5
  AST_SHR_FORCED: assert property (@(posedge clk) disable iff (rst)
    int_sel |=> s_oe);  // R6
  AST_POL_LOW: assert property (@(posedge clk) disable iff (rst)
    (active_low && los[1]) |=> !b_val);  // R11
endmodule

// File: rtl/clk_alarm_combiner.sv
module clk_alarm_combiner
  import clk_alarm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LOS-1:0]   los_raw,
  input  logic [NUM_FOS-1:0]   fos_raw,
  input  logic                 align_alarm,
  input  logic                 fsync_switch,
  input  logic                 fos_en,
  input  logic [NUM_EN-1:0]    pin_en,
  input  logic                 int_sel,
  input  logic                 active_low,
  input  logic [NUM_FLAGS-1:0] mask,
  input  logic [NUM_FLAGS-1:0] clr_flags,
  output logic                 pina_val,
  output logic                 pina_oe,
  output logic                 pinb_val,
  output logic                 pinb_oe,
  output logic                 pinc_val,
  output logic                 pinc_oe,
  output logic                 shr_val,
  output logic                 shr_oe,
  output logic [NUM_FLAGS-1:0] raw_status,
  output logic [NUM_FLAGS-1:0] sticky_status,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] flags_in;
  logic                 irq_next;

  assign flags_in = {fos_raw, los_raw};

  alarm_flag_bank #(.WIDTH(NUM_FLAGS)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .raw_in   (flags_in),
    .clr      (clr_flags),
    .mask     (mask),
    .raw_q    (raw_status),
    .sticky_q (sticky_status),
    .irq_next (irq_next),
    .irq_q    (irq)
  );

  alarm_pin_drive u_pins (
    .clk        (clk),
    .rst        (rst),
    .los        (los_raw),
    .fos        (fos_raw),
    .align      (align_alarm),
    .fsync      (fsync_switch),
    .fos_en     (fos_en),
    .pin_en     (pin_en),
    .int_sel    (int_sel),
    .active_low (active_low),
    .irq_level  (irq_next),
    .a_val      (pina_val),
    .a_oe       (pina_oe),
    .b_val      (pinb_val),
    .b_oe       (pinb_oe),
    .c_val      (pinc_val),
    .c_oe       (pinc_oe),
    .s_val      (shr_val),
    .s_oe       (shr_oe)
  );

  AST_RAW_MIRROR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw_status == $past(flags_in)));  // R7
endmodule

// File: tb/clk_alarm_combiner_bench.sv
module clk_alarm_combiner_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] los_raw = '0;
  logic [1:0] fos_raw = '0;
  logic       align_alarm = 1'b0, fsync_switch = 1'b0, fos_en = 1'b0;
  logic [2:0] pin_en = '0;
  logic       int_sel = 1'b0, active_low = 1'b0;
  logic [5:0] mask = '0, clr_flags = '0;
  logic       pina_val, pina_oe, pinb_val, pinb_oe, pinc_val, pinc_oe;
  logic       shr_val, shr_oe, irq;
  logic [5:0] raw_status, sticky_status;

  clk_alarm_combiner u_clk_alarm_combiner (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int         due;
    logic       av, aoe, bv, boe, cv, coe, sv, soe, irq;
    logic [5:0] raw, sticky;
    logic       isel, low, clr_any;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0] s_los = '0;
  logic [1:0] s_fos = '0;
  logic       s_align = 0, s_fsync = 0, s_fos_en = 0, s_isel = 0, s_low = 0;
  logic [2:0] s_en = '0;
  logic [5:0] s_mask = '0, s_clr = '0;
  logic [5:0] m_prev = '0, m_sticky = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    exp_t e;
    logic [5:0] raw, rise;
    logic a, b, s;
    @(negedge clk);
    los_raw = s_los; fos_raw = s_fos; align_alarm = s_align;
    fsync_switch = s_fsync; fos_en = s_fos_en; pin_en = s_en;
    int_sel = s_isel; active_low = s_low; mask = s_mask; clr_flags = s_clr;
    raw  = {s_fos, s_los};
    rise = raw & ~m_prev;
    e.due    = cyc + 1;
    e.raw    = raw;
    e.irq    = |(m_sticky & s_mask);
    e.sticky = (m_sticky & ~s_clr) | rise;
    a = s_los[0] | (s_los[2] & s_fsync) | (s_fos_en & s_fos[0]);
    b = s_los[1] | (s_los[3] & s_fsync) | (s_fos_en & s_fos[1]);
    s = s_isel ? e.irq : s_align;
    e.av = a ^ s_low; e.bv = b ^ s_low; e.cv = s_low; e.sv = s ^ s_low;
    e.aoe = s_en[0]; e.boe = s_en[1]; e.coe = 1'b0; e.soe = s_en[2] | s_isel;
    e.isel = s_isel; e.low = s_low; e.clr_any = |s_clr;
    m_prev   = raw;
    m_sticky = e.sticky;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        string pt;
        e = q.pop_front();
        pt = e.low ? " R11" : "";
        chk({"R1", pt}, {5'b0, pina_val}, {5'b0, e.av});
        chk({"R2", pt}, {5'b0, pinb_val}, {5'b0, e.bv});
        chk({"R3", pt}, {4'b0, pinc_oe, pinc_val}, {4'b0, e.coe, e.cv});
        chk(e.isel ? {"R6", pt} : {"R4", pt}, {5'b0, shr_val}, {5'b0, e.sv});
        chk("R5", {3'b0, pina_oe, pinb_oe, shr_oe}, {3'b0, e.aoe, e.boe, e.soe});
        chk("R7", raw_status, e.raw);
        chk(e.clr_any ? "R9" : "R8", sticky_status, e.sticky);
        chk("R10", {5'b0, irq}, {5'b0, e.irq});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hang expected finish", cyc);
    finish_run();
  end

  initial begin
    pin_en = 3'b111; active_low = 1'b1; los_raw = 4'hF;
    repeat (3) @(negedge clk);
    // R12: reset state, even with inputs active
    chk("R12 pins", {pina_val, pinb_val, pinc_val, shr_val, irq, 1'b0}, 6'b0);
    chk("R12 oe", {2'b0, pina_oe, pinb_oe, pinc_oe, shr_oe}, 6'b0);
    chk("R12 raw", raw_status, 6'b0);
    chk("R12 sticky", sticky_status, 6'b0);
    los_raw = '0; active_low = 1'b0; pin_en = '0;
    rst = 1'b0;

    s_en = 3'b111;
    s_los = 4'b0001; step();                   // R1 own LOS, R8 sticky set
    s_los = 4'b0101; step();
    s_los = 4'b0100; step();                   // R1 gated off without fsync
    s_fsync = 1; step();                       // R1 frame-sync LOS counted
    s_los = 4'b1100; step();                   // R2 frame-sync LOS
    s_fsync = 0; s_los = 4'b0000; step();      // R2 gated off
    s_fos = 2'b01; step();                     // R1 FOS disabled
    s_fos_en = 1; step();                      // R1 FOS enabled
    s_fos = 2'b11; step();                     // R2 FOS enabled
    s_mask = 6'b010000; step();                // R10 masked flag raises irq
    step();
    s_mask = 6'b000000; step();                // R10 mask off
    s_fos = 2'b00; s_clr = 6'b111111; step();  // R9 clear all
    s_clr = '0; s_mask = 6'b111111; step();    // R10 no flags, no irq
    s_los = 4'b0001; step();
    s_los = 4'b0000; step();
    s_clr = 6'b000001; s_los = 4'b0001; step(); // R9 set wins over clear
    s_clr = '0; s_isel = 1; s_en = 3'b000; step(); // R6 shared carries irq, oe forced
    step();
    s_clr = 6'b111111; step();                  // R6 irq falls on shared pin
    s_clr = '0; s_low = 1; step();              // R11 inverted levels
    s_isel = 0; s_align = 1; s_en = 3'b100; step(); // R4, R5
    s_low = 0; step();
    s_en = 3'b000; s_align = 0; step();         // R5 enables off
    s_en = 3'b011; s_fsync = 1; s_los = 4'b1000; step(); // R2 via frame-sync

    for (int k = 0; k < 300; k++) begin
      {s_los, s_fos} = 6'($urandom);
      {s_align, s_fsync, s_fos_en, s_isel, s_low} = 5'($urandom);
      s_en   = 3'($urandom);
      s_mask = 6'($urandom);
      s_clr  = ($urandom % 4 == 0) ? 6'($urandom) : 6'b0;
      step();
    end
    s_clr = '0;
    step();
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R7 scoreboard drain: actual %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule